// File: doc/BRIEF.md
# Linked-Cell Storage Manager

This block is the storage side of a hardware list evaluator. It owns a word memory in which each list cell takes two consecutive words: the car at the cell address and the cdr at the next address. Every word is a typed pointer made of a short type tag and a memory address. The evaluator sends one request at a time on a shared bus: an operation code plus a typed-pointer operand. The block reads cells, builds new cells, replaces cdr words and moves pointers in and out of its one internal register Q. It answers each finished request with a one-cycle step pulse, and the result word is valid during that pulse.

New cells come from a bump pointer that only moves upward. Address 0 is kept free so that the all-zero word can serve as nil. When the heap has no room left, an allocation request still finishes, but it writes nothing and sets a sticky full flag. A cell-building request takes its car from the bus and its cdr from Q (or nil), and it leaves the pointer to the new cell in Q. A chain of such requests therefore builds a list back to front with no extra transfers.

Top module: `listHeap`

## Requirements
- R1: After reset, step and heapFull are low and Q holds nil (type 0, address 0).
- R2: Each accepted request gives exactly one step pulse that lasts one cycle. Counting clock edges from the one that accepts the request, step is high after 1 edge for codes 0, 6 and 7 and for an allocation refused for lack of room, after 2 edges for codes 1, 2 and 5, and after 3 edges for codes 3 and 4.
- R3: Code 6 copies the bus type and address into Q. Code 7 leaves Q unchanged. For codes 0, 3, 4, 5, 6 and 7, the result bus shows Q as it stands after the request.
- R4: Code 1 returns the word at the operand address on the result bus. Code 2 returns the word at the operand address plus one.
- R5: Code 3 writes the bus word to the car of a new cell and the old Q to its cdr. Q then becomes a pointer to that cell with type 0.
- R6: Code 4 works like code 3, but the cdr of the new cell is nil (type 0, address 0), whatever Q holds.
- R7: Code 5 overwrites the cdr word of the cell named on the bus with Q and leaves that cell's car as it was.
- R8: The first cell is placed at address 2. Each successful allocation moves the next cell address up by 2.
- R9: An allocation whose cdr word would lie past the top of memory writes nothing and leaves Q unchanged. It sets heapFull, and heapFull then stays set until reset.
- R10: While a request is in progress, including the cycle in which step is high, reqValid and the request bus are ignored.
- R11: Code 0 changes neither Q nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; sampled only while idle |
| reqOp | input | 3 | Operation code: 0 none, 1 car, 2 cdr, 3 cons, 4 cons with nil, 5 replace cdr, 6 load Q, 7 store Q |
| reqType | input | TYPE_W | Type field of the operand word |
| reqAddr | input | ADDR_W | Address field of the operand word |
| step | output | 1 | One-cycle completion pulse |
| resType | output | TYPE_W | Type field of the result word, valid with step |
| resAddr | output | ADDR_W | Address field of the result word, valid with step |
| heapFull | output | 1 | Sticky flag for a refused allocation |

## Verification
The assertions check on every cycle that step never lasts more than one cycle, that the next cell address only ever moves up by exactly one cell, that the full flag never clears once set, that no allocation write lands once the heap is out of room, that Q holds a list-typed pointer right after an allocation, and that a request seen while busy does not disturb the latched operation. The bench scenarios are the only way to show the contents of the cells. Only they can show that the car and cdr read back as written, that a cdr replacement leaves the car alone, that a nil cdr differs from a Q cdr, and that a refused allocation leaves Q and earlier cells unchanged. They also measure how many cycles each kind of request takes.

// File: rtl/listHeapPkg.sv
package listHeapPkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_CAR    = 3'd1,
    OP_CDR    = 3'd2,
    OP_CONS   = 3'd3,
    OP_NCONS  = 3'd4,
    OP_RPLACD = 3'd5,
    OP_LOADQ  = 3'd6,
    OP_STOREQ = 3'd7
  } heapOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WCAR,
    ST_WCDR,
    ST_DONE
  } heapSt_e;

  typedef enum logic [1:0] {
    AD_OPER,
    AD_OPER_NEXT,
    AD_FREE,
    AD_FREE_NEXT
  } addrSel_e;

  typedef enum logic [1:0] {
    WD_OPER,
    WD_Q,
    WD_NIL
  } dataSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     latch;
    addrSel_e addrSel;
    dataSel_e dataSel;
    logic     memWe;
    logic     memRd;
    logic     qFromBus;
    logic     qFromFree;
    logic     freeAdv;
    logic     setFull;
  } strobe_t;

endpackage

// File: rtl/listHeapCtrl.sv
module listHeapCtrl
  import listHeapPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       roomLeft,
  output logic       step,
  output strobe_t    stb
);

  heapSt_e state, nextSt;
  heapOp_e curOp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curOp <= OP_NOP;
    end else begin
      state <= nextSt;
      if (stb.latch) curOp <= heapOp_e'(reqOp);
    end
  end

  always_comb begin
    stb    = '0;
    nextSt = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.latch = 1'b1;
          case (heapOp_e'(reqOp))
            OP_CAR, OP_CDR: nextSt = ST_READ;
            OP_CONS, OP_NCONS: begin
              if (roomLeft) nextSt = ST_WCAR;
              else begin
                stb.setFull = 1'b1;
                nextSt      = ST_DONE;
              end
            end
            OP_RPLACD: nextSt = ST_WCDR;
            OP_LOADQ: begin
              stb.qFromBus = 1'b1;
              nextSt       = ST_DONE;
            end
            default: nextSt = ST_DONE;
          endcase
        end
      end
      ST_READ: begin
        stb.addrSel = (curOp == OP_CDR) ? AD_OPER_NEXT : AD_OPER;
        stb.memRd   = 1'b1;
        nextSt      = ST_DONE;
      end
      ST_WCAR: begin
        stb.addrSel = AD_FREE;
        stb.dataSel = WD_OPER;
        stb.memWe   = 1'b1;
        nextSt      = ST_WCDR;
      end
      ST_WCDR: begin
        stb.memWe = 1'b1;
        if (curOp == OP_RPLACD) begin
          stb.addrSel = AD_OPER_NEXT;
          stb.dataSel = WD_Q;
        end else begin
          stb.addrSel   = AD_FREE_NEXT;
          stb.dataSel   = (curOp == OP_NCONS) ? WD_NIL : WD_Q;
          stb.qFromFree = 1'b1;
          stb.freeAdv   = 1'b1;
        end
        nextSt = ST_DONE;
      end
      ST_DONE: nextSt = ST_IDLE;
      default: nextSt = ST_IDLE;
    endcase
  end

  assign step = (state == ST_DONE);

  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    step |=> !step); // R2

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && reqValid) |=> $stable(curOp)); // R10

endmodule

// File: rtl/listHeapPath.sv
module listHeapPath
  import listHeapPkg::*;
#(
  parameter int TYPE_W = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [TYPE_W-1:0] busType,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              roomLeft,
  output logic [TYPE_W-1:0] resType,
  output logic [ADDR_W-1:0] resAddr,
  output logic              heapFull
);

  localparam int WORD_W = TYPE_W + ADDR_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int FREE_W = ADDR_W + 1;
  localparam logic [FREE_W-1:0] FIRST_CELL = FREE_W'(2);
  localparam logic [FREE_W-1:0] LAST_CELL  = FREE_W'(DEPTH - 2);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [TYPE_W-1:0] operType, qType;
  logic [ADDR_W-1:0] operAddr, qAddr;
  logic [FREE_W-1:0] freePtr;
  logic [WORD_W-1:0] rdWord, wrWord;
  logic [ADDR_W-1:0] wordAddr;
  logic              resMem, fullFlag;

  assign roomLeft = (freePtr <= LAST_CELL);

  always_comb begin
    case (stb.addrSel)
      AD_OPER:      wordAddr = operAddr;
      AD_OPER_NEXT: wordAddr = operAddr + ADDR_W'(1);
      AD_FREE:      wordAddr = freePtr[ADDR_W-1:0];
      default:      wordAddr = freePtr[ADDR_W-1:0] + ADDR_W'(1);
    endcase
    case (stb.dataSel)
      WD_OPER: wrWord = {operType, operAddr};
      WD_Q:    wrWord = {qType, qAddr};
      default: wrWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (stb.memWe) mem[wordAddr] <= wrWord;
    if (stb.memRd) rdWord <= mem[wordAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      operType <= '0;
      operAddr <= '0;
      qType    <= '0;
      qAddr    <= '0;
      freePtr  <= FIRST_CELL;
      fullFlag <= 1'b0;
      resMem   <= 1'b0;
    end else begin
      if (stb.latch) begin
        operType <= busType;
        operAddr <= busAddr;
        resMem   <= 1'b0;
      end
      if (stb.memRd) resMem <= 1'b1;
      if (stb.qFromBus) begin
        qType <= busType;
        qAddr <= busAddr;
      end else if (stb.qFromFree) begin
        qType <= '0;
        qAddr <= freePtr[ADDR_W-1:0];
      end
      if (stb.freeAdv) freePtr <= freePtr + FREE_W'(2);
      if (stb.setFull) fullFlag <= 1'b1;
    end
  end

  assign resType  = resMem ? rdWord[WORD_W-1 -: TYPE_W] : qType;
  assign resAddr  = resMem ? rdWord[ADDR_W-1:0]         : qAddr;
  assign heapFull = fullFlag;

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(freePtr) |-> (freePtr == $past(freePtr) + FREE_W'(2))); // R8

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |=> fullFlag); // R9

  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memWe && (stb.addrSel == AD_FREE || stb.addrSel == AD_FREE_NEXT))
      |-> (!fullFlag && freePtr < FREE_W'(DEPTH))); // R9

  AST_Q_LIST: assert property (@(posedge clk) disable iff (!rstN)
    stb.qFromFree |=> (qType == '0)); // R5

endmodule

// File: rtl/listHeap.sv
module listHeap
  import listHeapPkg::*;
#(
  parameter int TYPE_W = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [TYPE_W-1:0] reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              step,
  output logic [TYPE_W-1:0] resType,
  output logic [ADDR_W-1:0] resAddr,
  output logic              heapFull
);

  strobe_t stb;
  logic    roomLeft;

  listHeapCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .roomLeft (roomLeft),
    .step     (step),
    .stb      (stb)
  );

  listHeapPath #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busType  (reqType),
    .busAddr  (reqAddr),
    .roomLeft (roomLeft),
    .resType  (resType),
    .resAddr  (resAddr),
    .heapFull (heapFull)
  );

endmodule

// File: tb/sim_listHeap.sv
module sim_listHeap;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 3;
  localparam int AW = 4;
  localparam int NVEC = 17;

  // {op, type, addr, expType, expAddr, latency}
  localparam logic [18:0] VEC [NVEC] = '{
    {3'd6, 3'd5, 4'd9, 3'd5, 4'd9,  2'd1},  // load Q
    {3'd7, 3'd0, 4'd0, 3'd5, 4'd9,  2'd1},  // store Q
    {3'd3, 3'd1, 4'd3, 3'd0, 4'd2,  2'd3},  // cons at 2
    {3'd1, 3'd0, 4'd2, 3'd1, 4'd3,  2'd2},  // car 2
    {3'd2, 3'd0, 4'd2, 3'd5, 4'd9,  2'd2},  // cdr 2 = old Q
    {3'd4, 3'd2, 4'd7, 3'd0, 4'd4,  2'd3},  // ncons at 4
    {3'd2, 3'd0, 4'd4, 3'd0, 4'd0,  2'd2},  // cdr 4 = nil
    {3'd1, 3'd0, 4'd4, 3'd2, 4'd7,  2'd2},  // car 4
    {3'd0, 3'd3, 4'd3, 3'd0, 4'd4,  2'd1},  // nop keeps Q
    {3'd6, 3'd6, 4'd1, 3'd6, 4'd1,  2'd1},  // load Q
    {3'd5, 3'd0, 4'd2, 3'd6, 4'd1,  2'd2},  // replace cdr of 2
    {3'd2, 3'd0, 4'd2, 3'd6, 4'd1,  2'd2},  // cdr 2 replaced
    {3'd1, 3'd0, 4'd2, 3'd1, 4'd3,  2'd2},  // car 2 untouched
    {3'd3, 3'd4, 4'd4, 3'd0, 4'd6,  2'd3},  // cons at 6
    {3'd3, 3'd0, 4'd6, 3'd0, 4'd8,  2'd3},  // cons at 8
    {3'd2, 3'd0, 4'd8, 3'd0, 4'd6,  2'd2},  // cdr 8 = pointer to 6
    {3'd1, 3'd0, 4'd6, 3'd4, 4'd4,  2'd2}   // car 6
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [2:0]    reqOp = '0;
  logic [TW-1:0] reqType = '0;
  logic [AW-1:0] reqAddr = '0;
  logic          step;
  logic [TW-1:0] resType;
  logic [AW-1:0] resAddr;
  logic          heapFull;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  listHeap #(.TYPE_W(TW), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqType(reqType), .reqAddr(reqAddr), .step(step),
    .resType(resType), .resAddr(resAddr), .heapFull(heapFull)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd1, 3'd2: return "R4";
      3'd3:       return "R5";
      3'd4:       return "R6";
      3'd5:       return "R7";
      3'd0:       return "R11";
      default:    return "R3";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] op, input logic [TW-1:0] t, input logic [AW-1:0] a,
                      output logic [TW-1:0] rt, output logic [AW-1:0] ra, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqType = t; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!step && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rt = resType;
    ra = resAddr;
    @(negedge clk);
    chk("R2", "step width", int'(step), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] rt;
    logic [AW-1:0] ra;
    int lat;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "step after reset", int'(step), 0);
    chk("R1", "heapFull after reset", int'(heapFull), 0);
    doOp(3'd7, '0, '0, rt, ra, lat);
    chk("R1", "Q type after reset", int'(rt), 0);
    chk("R1", "Q addr after reset", int'(ra), 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [18:0] v;
      v = VEC[i];
      doOp(v[18:16], v[15:13], v[12:9], rt, ra, lat);
      chk(tagOf(v[18:16]), $sformatf("vec %0d type", i), int'(rt), int'(v[8:6]));
      chk(tagOf(v[18:16]), $sformatf("vec %0d addr", i), int'(ra), int'(v[5:2]));
      chk("R2", $sformatf("vec %0d latency", i), lat, int'(v[1:0]));
    end

    // R8 fill the rest of the heap: cells 10, 12, 14
    for (int k = 0; k < 3; k++) begin
      doOp(3'd4, 3'd1, 4'd1, rt, ra, lat);
      chk("R8", "fill cell addr", int'(ra), 10 + 2*k);
      chk("R8", "fill cell type", int'(rt), 0);
    end
    chk("R9", "heapFull before overflow", int'(heapFull), 0);

    // R9 refused allocation
    doOp(3'd3, 3'd5, 4'd5, rt, ra, lat);
    chk("R9", "refused alloc latency", lat, 1);
    chk("R9", "heapFull set", int'(heapFull), 1);
    chk("R9", "Q addr kept", int'(ra), 14);
    doOp(3'd4, 3'd2, 4'd2, rt, ra, lat);
    chk("R9", "heapFull sticky", int'(heapFull), 1);
    doOp(3'd7, '0, '0, rt, ra, lat);
    chk("R9", "Q after refusals", int'(ra), 14);
    doOp(3'd1, 3'd0, 4'd14, rt, ra, lat);
    chk("R9", "last cell car intact type", int'(rt), 1);
    chk("R9", "last cell car intact addr", int'(ra), 1);

    // R10 request held during busy and step cycles is ignored
    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'd6; reqType = 3'd1; reqAddr = 4'd1;
    @(negedge clk);
    chk("R10", "step for load Q", int'(step), 1);
    reqOp = 3'd6; reqType = 3'd7; reqAddr = 4'd7;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10", "no second step", int'(step), 0);
    doOp(3'd7, '0, '0, rt, ra, lat);
    chk("R10", "Q type unchanged", int'(rt), 1);
    chk("R10", "Q addr unchanged", int'(ra), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule